// File: doc/BRIEF.md
# Write-Through Register File with Same-Cycle Bypass

This block is the architectural integer register store of a five-stage in-order pipeline. It holds a bank of general registers that the decode stage reads through two independent read ports while the writeback stage updates one register through a single write port. All three accesses proceed in the same clock cycle without arbitration or stalls.

A write commits to storage at a rising clock edge. A read that names the register being written in that same cycle already returns the incoming value. The effect matches committing the write early in the cycle and reading late, but every flop uses the one rising edge. The pipeline therefore needs no separate forwarding path for an instruction three slots behind the producer, which saves one cycle of dependency penalty.

Register 0 is a hard zero: it never stores anything and is never bypassed. Reads are combinational from the address inputs. While the reset input is low, and for two edges after it is released, writes and bypass are suppressed; register contents are never cleared.

Top module: `rf_bypass_top`

## Requirements
- R1: The file holds 32 registers of 32 bits addressed by 5-bit indices, and a value written to register k (k from 1 to 31) is returned by either read port in any later cycle until register k is written again.
- R2: Both read ports and the write port operate in the same cycle with no interference: each read port returns the value of its own address whatever the other port and the write port do.
- R3: A register changes only at a rising clock edge with wr_en high; with wr_en low, a matching write address has no effect on the read data in that cycle or afterwards.
- R4: When wr_en is high, writes are armed, wr_addr is non-zero and a read address equals wr_addr, that read port returns wr_data in the same cycle, before the edge that stores it.
- R5: The bypass is applied per port: both ports can return the same freshly written value, and a port whose address does not match returns the stored value.
- R6: Address 0 always reads as 32'h0000_0000 on both ports, a write to address 0 is discarded, and it is not bypassed.
- R7: While rst_n is low, and until the second rising edge after rst_n goes high, writes are discarded and not bypassed; register contents already stored are kept across a reset.
- R8: Read data follows a change of read address within the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en | input | 1 | Write enable for the writeback port |
| wr_addr | input | 5 | Register index written |
| wr_data | input | 32 | Value written |
| rd_a_addr | input | 5 | Register index for read port A |
| rd_a_data | output | 32 | Read value of port A |
| rd_b_addr | input | 5 | Register index for read port B |
| rd_b_data | output | 32 | Read value of port B |

## Verification
The collision that matters is a writeback to a register and a decode read of that same register in one cycle. The bench provokes it by driving a write and one or both read addresses to the same index in a single cycle, sometimes to the same register cycle after cycle. It judges the read data before the storing edge against the new value. It also covers the cases where the bypass must stay silent (address 0, wr_en low, reset in progress), which must still return the old stored value.

// File: rtl/rf_pkg.sv
`timescale 1ns/1ps
package rf_pkg;
  localparam int unsigned RF_WIDTH = 32;
  localparam int unsigned RF_DEPTH = 32;
  localparam int unsigned RF_RST_STAGES = 2;

  // Source chosen for one read port in a cycle.
  typedef enum logic [1:0] {
    SRC_ZERO   = 2'd0,
    SRC_BYPASS = 2'd1,
    SRC_STORE  = 2'd2
  } rd_src_e;
endpackage

// File: rtl/rf_rst_sync.sv
`timescale 1ns/1ps
module rf_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic armed
);
  logic [STAGES-1:0] stg_q;
  logic [STAGES-1:0] stg_d;

  always_comb begin
    stg_d = {stg_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= '0;
    else        stg_q <= stg_d;
  end

  assign armed = stg_q[STAGES-1];
endmodule

// File: rtl/rf_store.sv
`timescale 1ns/1ps
module rf_store #(
  parameter  int unsigned WIDTH = 32,
  parameter  int unsigned DEPTH = 32,
  localparam int unsigned AW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             wr_live,
  input  logic [AW-1:0]    wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  output logic [WIDTH-1:0] rows [DEPTH]
);
  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    if (g == 0) begin : g_zero
      assign rows[g] = '0;
    end else begin : g_reg
      logic             ld;
      logic [WIDTH-1:0] d;
      logic [WIDTH-1:0] q;

      always_comb begin
        ld = wr_live && (wr_addr == AW'(g));
        d  = ld ? wr_data : q;
      end

      always_ff @(posedge clk) begin
        q <= d;
      end

      assign rows[g] = q;
    end
  end
endmodule

// File: rtl/rf_read_port.sv
`timescale 1ns/1ps
module rf_read_port
  import rf_pkg::*;
#(
  parameter  int unsigned WIDTH = 32,
  parameter  int unsigned DEPTH = 32,
  localparam int unsigned AW    = $clog2(DEPTH)
) (
  input  logic [AW-1:0]    rd_addr,
  input  logic [WIDTH-1:0] rows [DEPTH],
  input  logic             wr_live,
  input  logic [AW-1:0]    wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  output logic [WIDTH-1:0] rd_data
);
  rd_src_e src;

  always_comb begin
    if (rd_addr == '0)                          src = SRC_ZERO;
    else if (wr_live && (wr_addr == rd_addr))   src = SRC_BYPASS;
    else                                        src = SRC_STORE;
  end

  always_comb begin
    case (src)
      SRC_ZERO:   rd_data = '0;
      SRC_BYPASS: rd_data = wr_data;
      default:    rd_data = rows[rd_addr];
    endcase
  end
endmodule

// File: rtl/rf_bypass_top.sv
`timescale 1ns/1ps
module rf_bypass_top
  import rf_pkg::*;
#(
  parameter  int unsigned WIDTH = RF_WIDTH,
  parameter  int unsigned DEPTH = RF_DEPTH,
  localparam int unsigned AW    = $clog2(DEPTH),
  localparam int unsigned NRD   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [AW-1:0]    rd_a_addr,
  output logic [WIDTH-1:0] rd_a_data,
  input  logic [AW-1:0]    rd_b_addr,
  output logic [WIDTH-1:0] rd_b_data
);
  logic             wr_armed;
  logic             wr_live;
  logic [WIDTH-1:0] rows [DEPTH];
  logic [AW-1:0]    rd_addr_v [NRD];
  logic [WIDTH-1:0] rd_data_v [NRD];

  rf_rst_sync #(.STAGES(RF_RST_STAGES)) u_rst (
    .clk   (clk),
    .rst_n (rst_n),
    .armed (wr_armed)
  );

  // A write is live only when armed and aimed at a real register.
  always_comb begin
    wr_live = wr_en && wr_armed && (wr_addr != '0);
  end

  rf_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
    .clk     (clk),
    .wr_live (wr_live),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rows    (rows)
  );

  assign rd_addr_v[0] = rd_a_addr;
  assign rd_addr_v[1] = rd_b_addr;

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    rf_read_port #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_rd (
      .rd_addr (rd_addr_v[p]),
      .rows    (rows),
      .wr_live (wr_live),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .rd_data (rd_data_v[p])
    );
  end

  assign rd_a_data = rd_data_v[0];
  assign rd_b_data = rd_data_v[1];
endmodule

// File: rtl/rf_bypass_chk.sv
`timescale 1ns/1ps
module rf_bypass_chk #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned AW    = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_armed,
  input logic             wr_en,
  input logic [AW-1:0]    wr_addr,
  input logic [WIDTH-1:0] wr_data,
  input logic [AW-1:0]    rd_a_addr,
  input logic [WIDTH-1:0] rd_a_data,
  input logic [AW-1:0]    rd_b_addr,
  input logic [WIDTH-1:0] rd_b_data
);
  logic wr_go;
  assign wr_go = wr_en && wr_armed && (wr_addr != '0);

  assert_zero_a_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_a_addr == '0) |-> (rd_a_data == '0));
  assert_zero_b_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_b_addr == '0) |-> (rd_b_data == '0));

  assert_bypass_a_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_go && (wr_addr == rd_a_addr)) |-> (rd_a_data == wr_data));
  assert_bypass_b_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_go && (wr_addr == rd_b_addr)) |-> (rd_b_data == wr_data));

  assert_keep_a_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_go) && (rd_a_addr == $past(wr_addr)) &&
     !(wr_go && (wr_addr == rd_a_addr))) |-> (rd_a_data == $past(wr_data)));
  assert_keep_b_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_go) && (rd_b_addr == $past(wr_addr)) &&
     !(wr_go && (wr_addr == rd_b_addr))) |-> (rd_b_data == $past(wr_data)));
endmodule

bind rf_bypass_top rf_bypass_chk #(.WIDTH(WIDTH), .AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_armed  (wr_armed),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .wr_data   (wr_data),
  .rd_a_addr (rd_a_addr),
  .rd_a_data (rd_a_data),
  .rd_b_addr (rd_b_addr),
  .rd_b_data (rd_b_data)
);

// File: tb/rf_bypass_top_tb_top.sv
`timescale 1ns/1ps
module rf_bypass_top_tb_top;
  logic        clk   = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [4:0]  rd_a_addr = '0;
  logic [4:0]  rd_b_addr = '0;
  logic [31:0] rd_a_data;
  logic [31:0] rd_b_data;

  int checks = 0;
  int errors = 0;
  logic        armed = 1'b0;
  logic [31:0] shadow [32];

  always #2 clk = ~clk;

  rf_bypass_top dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_a_addr(rd_a_addr), .rd_a_data(rd_a_data),
    .rd_b_addr(rd_b_addr), .rd_b_data(rd_b_data)
  );

  function automatic logic [31:0] predict(input logic [4:0] a);
    if (a == 5'd0) return 32'h0;
    if (wr_en && armed && (wr_addr == a)) return wr_data;
    return shadow[a];
  endfunction

  task automatic check(input logic [31:0] act, input logic [31:0] exp,
                       input string req, input string port);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s port %s actual=%h expected=%h", req, port, act, exp);
    end
  endtask

  // One cycle: drive after the falling edge, check before the rising edge.
  task automatic step(input logic we, input logic [4:0] wa, input logic [31:0] wd,
                      input logic [4:0] ra, input logic [4:0] rb, input string req);
    @(negedge clk);
    wr_en = we; wr_addr = wa; wr_data = wd; rd_a_addr = ra; rd_b_addr = rb;
    #1;
    check(rd_a_data, predict(ra), req, "A");
    check(rd_b_data, predict(rb), req, "B");
    @(posedge clk);
    if (we && armed && wa != 5'd0) shadow[wa] = wd;
  endtask

  task automatic t_reset_state;
    step(1'b1, 5'd0, 32'h1111_2222, 5'd0, 5'd0, "R7_reset_zero");
    @(negedge clk); rst_n = 1'b1;
    repeat (3) step(1'b0, 5'd0, 32'h0, 5'd0, 5'd0, "R6");
    armed = 1'b1;
  endtask

  task automatic t_zero;
    step(1'b1, 5'd0, 32'hDEAD_BEEF, 5'd0, 5'd0, "R6_write_x0");
    step(1'b0, 5'd0, 32'h0, 5'd0, 5'd0, "R6_after");
  endtask

  task automatic t_fill;
    for (int i = 1; i < 32; i++)
      step(1'b1, 5'(i), (32'h0101_0101 * i) ^ 32'hA500_0000, 5'(i-1), 5'(i), "R2_fill");
    for (int i = 0; i < 32; i++)
      step(1'b0, 5'd0, 32'h0, 5'(i), 5'(31-i), "R1_R8_readback");
  endtask

  task automatic t_bypass;
    step(1'b1, 5'd7, 32'h1234_5678, 5'd7, 5'd7, "R4_both");
    step(1'b1, 5'd9, 32'h0BAD_F00D, 5'd9, 5'd7, "R5_one");
    step(1'b1, 5'd11, 32'h5555_AAAA, 5'd3, 5'd11, "R5_other");
  endtask

  task automatic t_we_low;
    step(1'b0, 5'd7, 32'hFFFF_FFFF, 5'd7, 5'd7, "R3_we_low");
    step(1'b0, 5'd0, 32'h0, 5'd7, 5'd9, "R3_kept");
  endtask

  task automatic t_b2b;
    for (int k = 0; k < 4; k++)
      step(1'b1, 5'd12, 32'hC0DE_0000 + 32'(k), 5'd12, 5'd12, "R4_b2b");
    step(1'b1, 5'd13, 32'h7777_0001, 5'd12, 5'd13, "R1_b2b");
    step(1'b1, 5'd12, 32'h7777_0002, 5'd13, 5'd12, "R1_b2b_alt");
    step(1'b0, 5'd0, 32'h0, 5'd12, 5'd13, "R1_b2b_final");
  endtask

  task automatic t_reset_block;
    @(negedge clk); rst_n = 1'b0; armed = 1'b0;
    step(1'b1, 5'd7, 32'hBAD0_BAD0, 5'd7, 5'd7, "R7_no_bypass");
    @(negedge clk); rst_n = 1'b1;
    step(1'b1, 5'd9, 32'hBAD1_BAD1, 5'd9, 5'd0, "R7_release");
    step(1'b0, 5'd0, 32'h0, 5'd0, 5'd0, "R7_release2");
    armed = 1'b1;
    step(1'b0, 5'd0, 32'h0, 5'd7, 5'd9, "R7_kept");
  endtask

  initial begin
    for (int i = 0; i < 32; i++) shadow[i] = 32'h0;
    t_reset_state();
    t_zero();
    t_fill();
    t_bypass();
    t_we_low();
    t_b2b();
    t_reset_block();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule